// File: doc/BRIEF.md
# Set-Associative Cache with Shared Victim Buffer

This block is a read-only data cache built from a 4-way set-associative main array and a small fully associative side buffer. Lines pushed out of a full set are kept in the side buffer instead of being dropped. The result is extra associativity only for the sets that overflow: a set whose working set is one line larger than its four ways borrows a buffer entry, and with four entries up to four such sets are served at once. One set alone can use several entries.

A request is a byte address. The main array is looked up first. The side buffer counts only when the main set misses. A side-buffer hit swaps the found line with the line the set would replace. A miss in both sends one line-aligned read to the next level. When the response arrives the line is written into the set, and a valid line displaced from the set moves into the side buffer. One request is in flight at a time.

Lines are 64 bytes. Address bits [5:0] are the byte offset, the next log2(SETS) bits are the set index and the bits above are the tag. Each buffer entry keeps the full line address (tag and index), so it can hold a line from any set.

Top module: `vc_victim_cache`

## Requirements
- R1: During and after reset, `req_ready` is 1 and both `resp_valid` and `mem_req_valid` are 0. The first access to any line after reset is a full miss.
- R2: A request is accepted on a clock edge E0 where `req_valid` and `req_ready` are both 1. On a main-array hit, `resp_valid` is high for exactly one cycle after edge E1, with `resp_src` = 2'b01.
- R3: On a side-buffer hit, the response comes one cycle later than a main hit (after edge E2), with `resp_src` = 2'b10. The requested line moves into its home set. The line that set replaces takes the freed buffer entry, or the entry is invalidated if the replaced frame was empty. That entry becomes the most recently used.
- R4: On a full miss, `mem_req_valid` is high for exactly one cycle after E1, and `mem_req_addr` holds the line address with bits [5:0] zero. `resp_valid` rises one edge after the edge that samples `mem_resp_valid` high, with `resp_src` = 2'b11.
- R5: Replacement rules. A fill into a set uses its lowest-numbered invalid way. If no way is invalid, it uses a 3-bit tree pseudo-LRU: the root bit at 0 selects ways 0-1, and each child bit selects within its pair (0 picks the lower way). After each use of a way, the bits point away from that way. On a full miss, a valid displaced line enters the lowest-numbered invalid buffer entry, or else the least recently used entry.
- R6: Five lines mapping to one set, accessed in a repeating cycle, cause no next-level read after the first round.
- R7: Four sets that each overflow by one line at the same time all run without next-level reads after the first round.
- R8: The side buffer is consulted only when the main set misses, and no line is ever present in both structures.
- R9: While a request is in flight, `req_ready` is 0 and any `req_valid` is ignored: it produces no response and fetches no line.
- R10: `resp_data` always equals the full content of the requested line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Byte address of the request |
| req_ready | output | 1 | Block is idle and accepts a request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | LINE_W | Requested line |
| resp_src | output | 2 | Where the line came from: 01 main, 10 side buffer, 11 next level |
| mem_req_valid | output | 1 | One-cycle read request to the next level |
| mem_req_addr | output | ADDR_W | Line-aligned read address |
| mem_resp_valid | input | 1 | Next-level data present |
| mem_resp_data | input | LINE_W | Next-level line data |

## Verification
Counting from the accepting edge, a main hit responds after the first following edge, a side-buffer hit after the second, and a miss raises its next-level request after the first and responds one edge after the memory data is sampled. The bench drives and samples on falling edges and counts them from acceptance. It requires the strobe in exactly the expected cycle and flags any early strobe or unexpected request. The expected source of each line comes from a bench model of both replacement policies, updated in program order. This makes every swap and spill visible through the later hits and misses it causes.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_L1   = 2'b01,
    SRC_VIC  = 2'b10,
    SRC_MEM  = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_SWAP,
    ST_WAIT
  } state_e;
endpackage

// File: rtl/vc_line_ram.sv
module vc_line_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/vc_plru.sv
module vc_plru #(
  parameter int SETS = 16,
  localparam int IW = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] sel_idx,
  output logic [1:0]    victim_way,
  input  logic          touch_en,
  input  logic [1:0]    touch_way
);
  logic [2:0] tree [SETS];
  logic [2:0] cur;

  assign cur        = tree[sel_idx];
  assign victim_way = cur[0] ? {1'b1, cur[2]} : {1'b0, cur[1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree[s] <= '0;
    end else if (touch_en) begin
      tree[sel_idx][0] <= ~touch_way[1];
      if (touch_way[1]) tree[sel_idx][2] <= ~touch_way[0];
      else              tree[sel_idx][1] <= ~touch_way[0];
    end
  end

  // R5
  plru_away_chk: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> (sel_idx != $past(sel_idx)) || (victim_way != $past(touch_way)));
endmodule

// File: rtl/vc_lru.sv
module vc_lru #(
  parameter int N = 4,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch_en,
  input  logic [AW-1:0] touch_ent,
  output logic [AW-1:0] oldest
);
  logic [AW-1:0] age [N];
  logic [N-1:0]  old_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age[i] <= AW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++)
        if (age[i] < age[touch_ent]) age[i] <= age[i] + 1'b1;
      age[touch_ent] <= '0;
    end
  end

  always_comb begin
    oldest  = '0;
    old_vec = '0;
    for (int i = 0; i < N; i++) begin
      old_vec[i] = (age[i] == AW'(N - 1));
      if (old_vec[i]) oldest = AW'(i);
    end
  end

  // R5
  one_oldest_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(old_vec) == 1);
endmodule

// File: rtl/vc_victim_cache.sv
module vc_victim_cache
  import vc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int LINE_W = 512,
  parameter int SETS   = 16,
  parameter int VC_N   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [LINE_W-1:0] resp_data,
  output logic [1:0]        resp_src,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_resp_valid,
  input  logic [LINE_W-1:0] mem_resp_data
);
  localparam int WAYS  = 4;
  localparam int IDX_W = $clog2(SETS);
  localparam int LN_W  = ADDR_W - OFF_W;
  localparam int TAG_W = LN_W - IDX_W;
  localparam int VE_W  = (VC_N > 1) ? $clog2(VC_N) : 1;

  state_e            st;
  logic [LN_W-1:0]   line_q;
  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        way_q;
  logic [VE_W-1:0]   ent_q;

  logic [TAG_W-1:0]  l1_tag [WAYS][SETS];
  logic [SETS-1:0]   l1_val [WAYS];
  logic [LINE_W-1:0] rd_data [WAYS];

  logic [LN_W-1:0]   v_line [VC_N];
  logic [LINE_W-1:0] v_data [VC_N];
  logic [VC_N-1:0]   v_val;

  logic [WAYS-1:0]   l1_hit_vec;
  logic [VC_N-1:0]   vc_hit_vec;
  logic [1:0]        hit_way, inv_way, plru_way, pick_way, touch_way;
  logic              any_inv, any_vfree, plru_touch;
  logic [VE_W-1:0]   vc_ent, free_ent, lru_ent, ins_ent, vw_ent;
  logic              fill_en, old_val, vw_en, lru_touch;
  logic [LINE_W-1:0] fill_data;

  assign tag_q     = line_q[LN_W-1:IDX_W];
  assign idx_q     = line_q[IDX_W-1:0];
  assign req_ready = (st == ST_IDLE);

  // one data array per way
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    vc_line_ram #(.DEPTH(SETS), .WIDTH(LINE_W)) i_ram (
      .clk  (clk),
      .re   (req_ready && req_valid),
      .raddr(req_addr[OFF_W +: IDX_W]),
      .rdata(rd_data[w]),
      .we   (fill_en && (way_q == 2'(w))),
      .waddr(idx_q),
      .wdata(fill_data)
    );
    assign l1_hit_vec[w] = l1_val[w][idx_q] && (l1_tag[w][idx_q] == tag_q);
  end

  for (genvar e = 0; e < VC_N; e++) begin : g_vent
    assign vc_hit_vec[e] = v_val[e] && (v_line[e] == line_q);
  end

  always_comb begin
    hit_way = '0; inv_way = '0; any_inv = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (l1_hit_vec[w]) hit_way = 2'(w);
      if (!l1_val[w][idx_q]) begin inv_way = 2'(w); any_inv = 1'b1; end
    end
    vc_ent = '0; free_ent = '0; any_vfree = 1'b0;
    for (int e = VC_N - 1; e >= 0; e--) begin
      if (vc_hit_vec[e]) vc_ent = VE_W'(e);
      if (!v_val[e]) begin free_ent = VE_W'(e); any_vfree = 1'b1; end
    end
  end

  assign pick_way  = any_inv ? inv_way : plru_way;
  assign ins_ent   = any_vfree ? free_ent : lru_ent;
  assign fill_en   = (st == ST_SWAP) || ((st == ST_WAIT) && mem_resp_valid);
  assign fill_data = (st == ST_SWAP) ? v_data[ent_q] : mem_resp_data;
  assign old_val   = l1_val[way_q][idx_q];
  assign vw_en     = (st == ST_SWAP) || (fill_en && old_val);
  assign vw_ent    = (st == ST_SWAP) ? ent_q : ins_ent;
  assign lru_touch = vw_en;
  assign plru_touch = fill_en || ((st == ST_LOOK) && (|l1_hit_vec));
  assign touch_way  = (st == ST_LOOK) ? hit_way : way_q;

  vc_plru #(.SETS(SETS)) i_plru (
    .clk(clk), .rst(rst), .sel_idx(idx_q), .victim_way(plru_way),
    .touch_en(plru_touch), .touch_way(touch_way)
  );

  vc_lru #(.N(VC_N)) i_lru (
    .clk(clk), .rst(rst), .touch_en(lru_touch), .touch_ent(vw_ent),
    .oldest(lru_ent)
  );

  // tag and side-buffer contents (no reset)
  always_ff @(posedge clk) begin
    if (fill_en) l1_tag[way_q][idx_q] <= tag_q;
    if (vw_en) begin
      v_line[vw_ent] <= {l1_tag[way_q][idx_q], idx_q};
      v_data[vw_ent] <= rd_data[way_q];
    end
  end

  // control, valid bits and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      line_q        <= '0;
      way_q         <= '0;
      ent_q         <= '0;
      v_val         <= '0;
      resp_valid    <= 1'b0;
      resp_data     <= '0;
      resp_src      <= SRC_NONE;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      for (int w = 0; w < WAYS; w++) l1_val[w] <= '0;
    end else begin
      resp_valid    <= 1'b0;
      mem_req_valid <= 1'b0;
      if (fill_en) l1_val[way_q][idx_q] <= 1'b1;
      if (vw_en)   v_val[vw_ent] <= old_val;
      case (st)
        ST_IDLE: if (req_valid) begin
          line_q <= req_addr[ADDR_W-1:OFF_W];
          st     <= ST_LOOK;
        end
        ST_LOOK: begin
          way_q <= pick_way;
          ent_q <= vc_ent;
          if (|l1_hit_vec) begin
            resp_valid <= 1'b1;
            resp_data  <= rd_data[hit_way];
            resp_src   <= SRC_L1;
            st         <= ST_IDLE;
          end else if (|vc_hit_vec) begin
            st <= ST_SWAP;
          end else begin
            mem_req_valid <= 1'b1;
            mem_req_addr  <= {line_q, {OFF_W{1'b0}}};
            st            <= ST_WAIT;
          end
        end
        ST_SWAP: begin
          resp_valid <= 1'b1;
          resp_data  <= v_data[ent_q];
          resp_src   <= SRC_VIC;
          st         <= ST_IDLE;
        end
        default: if (mem_resp_valid) begin
          resp_valid <= 1'b1;
          resp_data  <= mem_resp_data;
          resp_src   <= SRC_MEM;
          st         <= ST_IDLE;
        end
      endcase
    end
  end

  // R8
  excl_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOOK) |-> !((|l1_hit_vec) && (|vc_hit_vec)));
  // R3
  vc_unique_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vc_hit_vec));
  // R2
  resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);
  // R4
  mem_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));
  // R4
  mem_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);
  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/test_vc_victim_cache.sv
module test_vc_victim_cache;
  localparam int ADDR_W = 32;
  localparam int LINE_W = 512;
  localparam int MEM_LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready, resp_valid, mem_req_valid;
  logic [LINE_W-1:0] resp_data;
  logic [1:0] resp_src;
  logic [ADDR_W-1:0] mem_req_addr;
  logic mem_resp_valid = 1'b0;
  logic [LINE_W-1:0] mem_resp_data = '0;

  int tests = 0;
  int fails = 0;
  int cyc_total = 0;

  always #10 clk = ~clk;

  vc_victim_cache i_vc_victim_cache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
    .resp_src(resp_src), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_resp_valid(mem_resp_valid),
    .mem_resp_data(mem_resp_data)
  );

  function automatic logic [LINE_W-1:0] line_data(input logic [25:0] ln);
    return {16{({ln, 6'b0} ^ 32'h5A5A_1234)}};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bench model of both structures
  logic [21:0] m_tag [4][16];
  bit          m_val [4][16];
  bit   [2:0]  m_pl  [16];
  logic [25:0] v_ln  [4];
  bit          v_v   [4];
  int          v_age [4];

  task automatic model_reset();
    for (int s = 0; s < 16; s++) begin
      m_pl[s] = '0;
      for (int w = 0; w < 4; w++) m_val[w][s] = 0;
    end
    for (int e = 0; e < 4; e++) begin v_v[e] = 0; v_age[e] = e; end
  endtask

  task automatic pl_touch(input int s, input int w);
    m_pl[s][0] = (w < 2);
    if (w < 2) m_pl[s][1] = (w == 0); else m_pl[s][2] = (w == 2);
  endtask

  task automatic age_touch(input int e);
    for (int i = 0; i < 4; i++) if (v_age[i] < v_age[e]) v_age[i]++;
    v_age[e] = 0;
  endtask

  function automatic int pick_way(input int s);
    for (int w = 0; w < 4; w++) if (!m_val[w][s]) return w;
    if (!m_pl[s][0]) return m_pl[s][1] ? 1 : 0;
    return m_pl[s][2] ? 3 : 2;
  endfunction

  task automatic model_access(input logic [25:0] ln, output logic [1:0] src);
    int s, hw, ve, w, ins;
    logic [25:0] old;
    bit oldv;
    s = int'(ln[3:0]); hw = -1; ve = -1;
    for (int i = 0; i < 4; i++) if (m_val[i][s] && m_tag[i][s] == ln[25:4]) hw = i;
    for (int i = 0; i < 4; i++) if (v_v[i] && v_ln[i] == ln) ve = i;
    if (hw >= 0) begin
      src = 2'b01; pl_touch(s, hw);
      return;
    end
    w = pick_way(s); oldv = m_val[w][s]; old = {m_tag[w][s], ln[3:0]};
    if (ve >= 0) begin
      src = 2'b10;
      v_ln[ve] = old; v_v[ve] = oldv; age_touch(ve);
    end else begin
      src = 2'b11;
      if (oldv) begin
        ins = -1;
        for (int i = 3; i >= 0; i--) if (!v_v[i]) ins = i;
        if (ins < 0) for (int i = 0; i < 4; i++) if (v_age[i] == 3) ins = i;
        v_ln[ins] = old; v_v[ins] = 1; age_touch(ins);
      end
    end
    m_tag[w][s] = ln[25:4]; m_val[w][s] = 1; pl_touch(s, w);
  endtask

  logic [1:0] last_src;

  task automatic access(input logic [31:0] a, input bit poke, input logic [31:0] paddr);
    logic [1:0] exp;
    int n;
    bit memseen, got;
    model_access(a[31:6], exp);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; memseen = 0; got = 0;
    while (!got && n < 40) begin
      @(negedge clk); n++;
      if (mem_req_valid) begin
        memseen = 1;
        chk(exp == 2'b11, "R4 request only on full miss", 1, 0);
        chk(n == 1, "R4 request timing", n, 1);
        chk(mem_req_addr == {a[31:6], 6'b0}, "R4 aligned address", mem_req_addr, {a[31:6], 6'b0});
        for (int k = 0; k < MEM_LAT; k++) begin
          if (poke && k == 0) begin req_valid = 1'b1; req_addr = paddr; end
          @(negedge clk); n++;
          req_valid = 1'b0;
          chk(!resp_valid, "R4 no early response", resp_valid, 0);
          chk(!mem_req_valid, "R9 single fetch", mem_req_valid, 0);
        end
        mem_resp_valid = 1'b1; mem_resp_data = line_data(a[31:6]);
        @(negedge clk); n++;
        mem_resp_valid = 1'b0;
        chk(resp_valid, "R4 response after memory data", resp_valid, 1);
      end
      if (resp_valid) got = 1;
    end
    chk(got, "R2 response arrives", got, 1);
    chk(resp_src == exp, "R5 source per replacement model", resp_src, exp);
    chk(resp_data == line_data(a[31:6]), "R10 line data", resp_data[31:0], line_data(a[31:6]) & 32'hFFFF_FFFF);
    if (exp == 2'b01) chk(n == 1, "R2 main hit latency", n, 1);
    if (exp == 2'b10) chk(n == 2, "R3 side hit latency", n, 2);
    if (exp != 2'b11) chk(!memseen, "R8 no fetch on hit", memseen, 0);
    last_src = resp_src;
  endtask

  function automatic logic [31:0] mk(input int tag, input int idx);
    return {22'(tag), 4'(idx), 6'(($urandom % 64))};
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cyc_total++;
      if (cyc_total > 150000) begin
        fails++; tests++;
        $display("FAIL watchdog: actual %0d expected below 150000", cyc_total);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset outputs
    chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    chk(!resp_valid, "R1 resp idle in reset", resp_valid, 0);
    chk(!mem_req_valid, "R1 mem idle in reset", mem_req_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

    access(mk(3, 2), 0, 0);
    chk(last_src == 2'b11, "R1 first access misses", last_src, 3);
    access(mk(3, 2), 0, 0);
    chk(last_src == 2'b01, "R2 repeat hits main", last_src, 1);

    // R6 five lines in one set
    for (int r = 0; r < 3; r++)
      for (int t = 1; t <= 5; t++) begin
        access(mk(t, 5), 0, 0);
        if (r > 0) chk(last_src != 2'b11, "R6 no refetch", last_src, 1);
        if (r > 0 && t == 1) chk(last_src == 2'b10, "R3 swapped line hit", last_src, 2);
      end

    // R7 four overflowing sets
    for (int r = 0; r < 3; r++)
      for (int t = 1; t <= 5; t++)
        for (int s = 8; s < 12; s++) begin
          access(mk(t + 10, s), 0, 0);
          if (r > 0) chk(last_src != 2'b11, "R7 no refetch", last_src, 1);
        end

    // R5 sixth line pushes out the least recently used entry
    access(mk(40, 8), 0, 0);
    access(mk(11, 9), 0, 0);

    // R9 request during a miss is ignored
    access(mk(50, 14), 1, mk(51, 14));
    repeat (3) begin
      @(negedge clk);
      chk(!resp_valid && !mem_req_valid, "R9 ignored request silent", resp_valid, 0);
    end
    access(mk(51, 14), 0, 0);
    chk(last_src == 2'b11, "R9 ignored line not fetched", last_src, 3);

    // random mix over a small pool
    for (int i = 0; i < 400; i++)
      access(mk(int'($urandom % 7), int'($urandom % 4)), 0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule